// File: doc/BRIEF.md
# Synth Control Register Decoder

This block is the write-only host port of a polyphonic sound-generator core. A host presents an 8-bit byte, one address-select bit and a write strobe. Every write is captured, byte and address bit together, in a 9-bit input latch. A write to the control address (select = 0) reloads a five-bit mode register, a test flag and a persistent key-sync flag. Level outputs are then decoded from that small amount of state. A write to the parameter address (select = 1) raises a one-cycle strobe. The strobe tells the per-note parameter store that a new algorithm/feedback byte is waiting on `param_data`.

The decoded levels tell the store how to apply that byte. In broadcast mode the byte goes to every note. In single-note mode it goes to the note named by `note_idx`. When the test flag is set, the levels drive the core's test hooks. These hooks clear the phase accumulators, bypass output scaling and the output latch, reset the sequencing counters, and make the waveform lookup read the low-order phase bits. The parameter store, the accumulators and the output path all sit outside this block.

Top module: `synth_ctl_decoder`

## Requirements
- R1: On a clock edge with `wr_en` high and reset released, `param_data` takes `wr_data` and `latched_addr` takes `addr_sel`. Both are visible from the next cycle and hold until the next write.
- R2: A control write (select 0) loads byte bits [4:0] into the mode register. A parameter write (select 1), whatever its value, leaves the mode register, the test flag and the key-sync flag unchanged, as seen on every decoded output.
- R3: Key sync is controlled by a control write. Byte bit 5 sets `key_sync` and byte bit 6 clears it. If both are set, clear wins. If neither is set, `key_sync` keeps its value.
- R4: `bcast_mode` is high when the last control byte has bit 7 = 0, bit 4 = 1 and bit 2 = 0. Both 0x30 and 0x50 select it.
- R5: `single_mode` is high when the last control byte has bit 7 = 0 and bit 4 = 0. `note_idx` always shows byte bits [3:0], giving notes 0 to 15. `bcast_mode` and `single_mode` are never high together.
- R6: When the last control byte has bit 7 = 1, `phase_clr`, `scale_off` and `outlatch_bypass` are high. In that state both `bcast_mode` and `single_mode` are low.
- R7: `seq_reset` is high exactly when the last control byte has bit 7 = 1 and bit 0 = 1.
- R8: `low_phase_sel` is high exactly when the last control byte has bit 7 = 1 and bit 1 = 1.
- R9: A parameter write makes `param_wr` high for the one cycle after its edge. Back-to-back parameter writes keep it high for one cycle each. Control writes and idle cycles leave it low.
- R10: A synchronous active-low reset clears the latch, the mode register, the test flag, the key-sync flag and the strobe. The block then reads as single-note mode with note 0, and all test outputs are low.
- R11: Cycles without `wr_en` change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr_sel | input | 1 | 0 = control byte, 1 = algorithm/feedback byte |
| wr_data | input | 8 | Write data |
| param_wr | output | 1 | One-cycle strobe after a parameter write |
| param_data | output | 8 | Latched byte (new algorithm/feedback value) |
| latched_addr | output | 1 | Latched address bit |
| key_sync | output | 1 | Persistent key-sync flag |
| bcast_mode | output | 1 | Parameter byte goes to all notes |
| single_mode | output | 1 | Parameter byte goes to note `note_idx` only |
| note_idx | output | 4 | Target note for single-note updates |
| phase_clr | output | 1 | Test: hold phase accumulators clear |
| scale_off | output | 1 | Test: disable output scaling |
| outlatch_bypass | output | 1 | Test: bypass the output latch |
| seq_reset | output | 1 | Test: reset operator/note sequencing counters |
| low_phase_sel | output | 1 | Test: waveform lookup from low-order phase bits |

## Verification
The assertions assume that `wr_en`, `addr_sel` and `wr_data` are stable and known around every rising edge. They also assume that a parameter write is meant for the target chosen by the most recent control write. The stimulus changes inputs only on falling edges. It holds every control byte for at least one cycle before the parameter byte that depends on it, and it issues back-to-back parameter writes only as an explicit strobe case.

// File: rtl/synth_ctl_pkg.sv
// Package: shared widths, control-byte bit positions and the test-hook bundle.
// Assumes an 8-bit host byte; bit positions are fixed by the decode rules.
package synth_ctl_pkg;
    localparam int BYTE_W    = 8;
    localparam int MODE_W    = 5;
    localparam int NOTE_W    = 4;
    localparam int LATCH_W   = BYTE_W + 1;

    localparam int B_TEST    = 7;  // test flag
    localparam int B_KS_OFF  = 6;  // key-sync clear
    localparam int B_KS_ON   = 5;  // key-sync set
    localparam int B_BCAST   = 4;  // broadcast / single select (mode bit)
    localparam int B_BGUARD  = 2;  // must be 0 for broadcast (mode bit)
    localparam int B_LOWPH   = 1;  // low-phase select under test (mode bit)
    localparam int B_SEQ     = 0;  // sequencer reset under test (mode bit)

    typedef struct packed {
        logic phase_clr;
        logic scale_off;
        logic outlatch_bypass;
        logic seq_reset;
        logic low_phase_sel;
    } test_hooks_t;
endpackage

// File: rtl/synth_ctl_latch.sv
// Input latch: captures {address bit, byte} on every write and raises a
// one-cycle strobe when the write went to the parameter address.
// Assumes the MSB of din is the address bit.
module synth_ctl_latch #(
    parameter int W = synth_ctl_pkg::LATCH_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         pwr
);
    // Capture the write word; hold it between writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= din;
    end

    // Strobe for the cycle after each parameter-address write.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr <= 1'b0;
        else        pwr <= wr_en & din[W-1];
    end

    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(din)));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
    assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && din[W-1]) |=> pwr);
endmodule

// File: rtl/synth_ctl_mode.sv
// Mode state: a five-bit mode register, the test flag and the persistent
// key-sync flag. Only a control-address write (ld) may change any of them.
module synth_ctl_mode
    import synth_ctl_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [BW-1:0] byte_in,
    output logic [MW-1:0] mode_q,
    output logic          test_q,
    output logic          ks_q
);
    // Mode bits and test flag reload from each control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            test_q <= 1'b0;
        end else if (ld) begin
            mode_q <= byte_in[MW-1:0];
            test_q <= byte_in[B_TEST];
        end
    end

    // Key-sync flag: clear beats set, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ks_q <= 1'b0;
        else if (ld && byte_in[B_KS_OFF]) ks_q <= 1'b0;
        else if (ld && byte_in[B_KS_ON])  ks_q <= 1'b1;
    end

    assert_mode_only_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ($stable(mode_q) && $stable(test_q) && $stable(ks_q)));
    assert_ks_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && byte_in[B_KS_OFF]) |=> !ks_q);
    assert_ks_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !byte_in[B_KS_OFF] && !byte_in[B_KS_ON]) |=> $stable(ks_q));
endmodule

// File: rtl/synth_ctl_decode.sv
// Combinational decode of mode state into update-target levels and test hooks.
// Assumes mode_q holds control-byte bits [MW-1:0] and test_q holds bit 7.
module synth_ctl_decode
    import synth_ctl_pkg::*;
#(
    parameter int MW = MODE_W,
    parameter int NW = NOTE_W
) (
    input  logic [MW-1:0] mode_q,
    input  logic          test_q,
    output logic          bcast,
    output logic          single,
    output logic [NW-1:0] note,
    output test_hooks_t   hooks
);
    // Update-target select: only meaningful outside test mode.
    always_comb begin
        bcast  = !test_q && mode_q[B_BCAST] && !mode_q[B_BGUARD];
        single = !test_q && !mode_q[B_BCAST];
        note   = mode_q[NW-1:0];
    end

    // Test hooks: bit 7 gates every hook.
    always_comb begin
        hooks.phase_clr       = test_q;
        hooks.scale_off       = test_q;
        hooks.outlatch_bypass = test_q;
        hooks.seq_reset       = test_q && mode_q[B_SEQ];
        hooks.low_phase_sel   = test_q && mode_q[B_LOWPH];
    end
endmodule

// File: rtl/synth_ctl_decoder.sv
// Top: host write port of the sound-generator core. Latches each write,
// keeps the mode state and drives the parameter-store and test control lines.
// Assumes inputs are synchronous to clk and stable around the rising edge.
module synth_ctl_decoder
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              param_wr,
    output logic [BYTE_W-1:0] param_data,
    output logic              latched_addr,
    output logic              key_sync,
    output logic              bcast_mode,
    output logic              single_mode,
    output logic [NOTE_W-1:0] note_idx,
    output logic              phase_clr,
    output logic              scale_off,
    output logic              outlatch_bypass,
    output logic              seq_reset,
    output logic              low_phase_sel
);
    logic [LATCH_W-1:0] lat_q;
    logic [MODE_W-1:0]  mode_q;
    logic               test_q;
    test_hooks_t        hooks;

    synth_ctl_latch #(.W(LATCH_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .din   ({addr_sel, wr_data}),
        .q     (lat_q),
        .pwr   (param_wr)
    );

    synth_ctl_mode #(.BW(BYTE_W), .MW(MODE_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (wr_en && !addr_sel),
        .byte_in (wr_data),
        .mode_q  (mode_q),
        .test_q  (test_q),
        .ks_q    (key_sync)
    );

    synth_ctl_decode #(.MW(MODE_W), .NW(NOTE_W)) u_dec (
        .mode_q (mode_q),
        .test_q (test_q),
        .bcast  (bcast_mode),
        .single (single_mode),
        .note   (note_idx),
        .hooks  (hooks)
    );

    // Present the latch and the hook bundle on plain ports.
    always_comb begin
        param_data      = lat_q[BYTE_W-1:0];
        latched_addr    = lat_q[LATCH_W-1];
        phase_clr       = hooks.phase_clr;
        scale_off       = hooks.scale_off;
        outlatch_bypass = hooks.outlatch_bypass;
        seq_reset       = hooks.seq_reset;
        low_phase_sel   = hooks.low_phase_sel;
    end

    assert_target_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bcast_mode, single_mode}));
    assert_test_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_clr |-> (!bcast_mode && !single_mode));
    assert_seq_in_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_reset |-> (phase_clr && scale_off && outlatch_bypass));
    assert_lowph_in_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_phase_sel |-> phase_clr);
    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        param_wr |-> $past(wr_en && addr_sel));
    assert_ctl_write_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_sel) |=> !param_wr);
endmodule

// File: tb/synth_ctl_decoder_test.sv
`timescale 1ns/100ps
module synth_ctl_decoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic addr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic param_wr, latched_addr, key_sync, bcast_mode, single_mode;
    logic phase_clr, scale_off, outlatch_bypass, seq_reset, low_phase_sel;
    logic [7:0] param_data;
    logic [3:0] note_idx;

    always #2.5 clk = ~clk;

    synth_ctl_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_sel(addr_sel),
        .wr_data(wr_data), .param_wr(param_wr), .param_data(param_data),
        .latched_addr(latched_addr), .key_sync(key_sync),
        .bcast_mode(bcast_mode), .single_mode(single_mode), .note_idx(note_idx),
        .phase_clr(phase_clr), .scale_off(scale_off),
        .outlatch_bypass(outlatch_bypass), .seq_reset(seq_reset),
        .low_phase_sel(low_phase_sel)
    );

    typedef struct {
        string      tag;
        logic [7:0] data;
        logic       addr;
        logic       pwr;
        logic       ks;
        logic       bc;
        logic       sg;
        logic [3:0] note;
        logic       tr;
        logic       sr;
        logic       lp;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state, built from the requirement text.
    logic [7:0] m_data = 8'h00;
    logic       m_addr = 1'b0;
    logic [4:0] m_mode = 5'h00;
    logic       m_test = 1'b0;
    logic       m_ks   = 1'b0;

    function automatic exp_t build(input string tag, input logic pwr);
        exp_t e;
        e.tag  = tag;
        e.data = m_data;
        e.addr = m_addr;
        e.pwr  = pwr;
        e.ks   = m_ks;
        e.bc   = !m_test && m_mode[4] && !m_mode[2];
        e.sg   = !m_test && !m_mode[4];
        e.note = m_mode[3:0];
        e.tr   = m_test;
        e.sr   = m_test && m_mode[0];
        e.lp   = m_test && m_mode[1];
        return e;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Driver: one write, then the expected state for the following cycle.
    task automatic wr(input string tag, input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr_sel = a; wr_data = d;
        @(posedge clk); #1;
        m_data = d; m_addr = a;
        if (!a) begin
            m_mode = d[4:0];
            m_test = d[7];
            if (d[6])      m_ks = 1'b0;
            else if (d[5]) m_ks = 1'b1;
        end
        sb.push_back(build(tag, a));
    endtask

    task automatic idle(input string tag, input logic [7:0] junk);
        @(negedge clk);
        wr_en = 1'b0; addr_sel = junk[0]; wr_data = junk;
        @(posedge clk); #1;
        sb.push_back(build(tag, 1'b0));
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; addr_sel = 1'b1; wr_data = 8'hA5;
        @(posedge clk); #1;
        m_data = 8'h00; m_addr = 1'b0; m_mode = 5'h00; m_test = 1'b0; m_ks = 1'b0;
        sb.push_back(build(tag, 1'b0));
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
    endtask

    // Monitor: compare each expected item on the falling edge.
    initial begin
        forever begin : mon
            exp_t e;
            @(negedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(e.tag, "param_data R1",   param_data,      e.data);
                chk(e.tag, "latched_addr R1", latched_addr,    e.addr);
                chk(e.tag, "param_wr R9",     param_wr,        e.pwr);
                chk(e.tag, "key_sync R3",     key_sync,        e.ks);
                chk(e.tag, "bcast_mode R4",   bcast_mode,      e.bc);
                chk(e.tag, "single_mode R5",  single_mode,     e.sg);
                chk(e.tag, "note_idx R5",     note_idx,        e.note);
                chk(e.tag, "phase_clr R6",    phase_clr,       e.tr);
                chk(e.tag, "scale_off R6",    scale_off,       e.tr);
                chk(e.tag, "outlatch R6",     outlatch_bypass, e.tr);
                chk(e.tag, "seq_reset R7",    seq_reset,       e.sr);
                chk(e.tag, "low_phase R8",    low_phase_sel,   e.lp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset("R10_reset");
        wr("R4_bcast_sync_on", 1'b0, 8'h30);
        wr("R9_param_write", 1'b1, 8'h2A);
        idle("R11_idle_hold", 8'hFF);
        wr("R4_bcast_sync_off", 1'b0, 8'h50);
        wr("R5_single_note7", 1'b0, 8'h07);
        wr("R2_param_ignored", 1'b1, 8'hFF);
        wr("R4_guard_bit2", 1'b0, 8'h14);
        wr("R3_set", 1'b0, 8'h20);
        wr("R3_keep", 1'b0, 8'h0C);
        wr("R3_both_clear", 1'b0, 8'h60);
        wr("R5_note15", 1'b0, 8'h0F);
        wr("R5_note0", 1'b0, 8'h00);
        wr("R6_test", 1'b0, 8'h80);
        wr("R7_seq", 1'b0, 8'h81);
        wr("R8_lowph", 1'b0, 8'h82);
        wr("R2_param_in_test", 1'b1, 8'h00);
        wr("R7_R8_both", 1'b0, 8'h83);
        wr("R6_bcast_blocked", 1'b0, 8'h93);
        idle("R11_idle_test", 8'h00);
        wr("R3_set_after_test", 1'b0, 8'h3F);
        wr("R9_back2back_a", 1'b1, 8'h11);
        wr("R9_back2back_b", 1'b1, 8'h22);
        idle("R9_strobe_drop", 8'h5A);
        wr("R9_ctl_no_strobe", 1'b0, 8'h50);
        do_reset("R10_reset_again");
        idle("R10_after_reset", 8'hC3);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule